// File: doc/BRIEF.md
# DRAM Start-up and CAS-before-RAS Refresh Sequencer

This block takes care of bringing an asynchronous DRAM out of power-up and keeping its contents alive afterwards. Once reset is released it holds every strobe inactive for a programmable pause. It then runs a fixed number of dummy RAS-only cycles and raises an init-complete flag. From that point on, an interval timer earns one refresh credit per period.

While credits are outstanding, the block asks the memory controller for the strobe bus. Once the bus is granted, it plays out one CAS-before-RAS refresh per credit, back to back. Both byte CAS strobes fall together ahead of RAS, so the DRAM takes the row from its own internal counter. No address and no data are involved. Write enable and output enable stay high for the whole time, so the data bus is never driven.

The controller multiplexes the block's strobes onto the DRAM pins whenever the ownership output is high. All pause, interval and strobe timings are parameters counted in clock cycles.

Top module: `refresh_init_seq`

## Requirements
- R1: After reset is released, RAS and both CAS outputs stay high for at least PAUSE_CYC clock cycles.
- R2: After the pause, exactly INIT_CYCLES RAS pulses are issued with both CAS outputs high throughout. Only then does init_done go to 1, and it stays at 1 until reset.
- R3: After init_done rises, a refresh credit is earned every INTERVAL_CYC cycles. When credits are settled promptly, ref_req rises exactly INTERVAL_CYC cycles apart.
- R4: In a refresh, lcas_n and ucas_n fall together CAS_LEAD_CYC cycles before ras_n falls. They stay low while ras_n is low and rise in the same cycle as ras_n.
- R5: Every RAS pulse, whether for start-up or for refresh, holds ras_n low for exactly RAS_LOW_CYC cycles.
- R6: Between two RAS pulses, ras_n stays high for at least RAS_PRE_CYC cycles.
- R7: A refresh strobe sequence starts only in a cycle where ref_gnt is 1. With ref_gnt held at 0, no strobe moves after init_done.
- R8: Credits that are not settled accumulate up to PEND_MAX, and any further credits are dropped. On grant, exactly the accumulated number of refreshes is issued back to back. ref_req falls when no credit remains.
- R9: we_n and oe_n are 1 at all times after reset.
- R10: strobe_own is 1 from reset until init_done, and 1 during every refresh RAS pulse. It is 0 while the block is idle after start-up.
- R11: During reset, ras_n, lcas_n and ucas_n are 1, and init_done and ref_req are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_gnt | input | 1 | Controller grants the strobe bus for refresh |
| ref_req | output | 1 | At least one refresh credit is outstanding |
| init_done | output | 1 | Start-up sequence complete |
| strobe_own | output | 1 | Block's strobes should be muxed onto the DRAM pins |
| ras_n | output | 1 | Row strobe, active low |
| lcas_n | output | 1 | Lower-byte column strobe, active low |
| ucas_n | output | 1 | Upper-byte column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| oe_n | output | 1 | Output enable, held high |

## Verification
The hardest state to reach is a saturated credit counter whose drain does not overlap a fresh interval tick. Without that separation, the number of back-to-back refreshes would be ambiguous.

The stimulus withholds the grant and first synchronises to a ref_req rising edge, which marks a tick. It then waits five intervals plus a few cycles, so that credits have clipped at the limit and the next tick is still far away. Only then does it grant the bus, and the scoreboard expects exactly PEND_MAX refresh pulses with no pulse at any other time.

// File: rtl/refseq_pkg.sv
package refseq_pkg;

   typedef enum logic [1:0] {
      ENG_IDLE,
      ENG_CAS,
      ENG_RAS,
      ENG_PRE
   } eng_state_t;

   typedef enum logic [1:0] {
      PH_PAUSE,
      PH_INIT,
      PH_RUN
   } phase_t;

endpackage

// File: rtl/refseq_engine.sv
module refseq_engine
   import refseq_pkg::*;
#(
   parameter int CAS_LEAD_CYC = 1,
   parameter int RAS_LOW_CYC  = 5,
   parameter int RAS_PRE_CYC  = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   input  logic cbr,
   output logic ras_n,
   output logic cas_n,
   output logic busy,
   output logic done
);
   localparam int MAXC = (RAS_LOW_CYC > RAS_PRE_CYC) ?
                         ((RAS_LOW_CYC > CAS_LEAD_CYC) ? RAS_LOW_CYC : CAS_LEAD_CYC) :
                         ((RAS_PRE_CYC > CAS_LEAD_CYC) ? RAS_PRE_CYC : CAS_LEAD_CYC);
   localparam int CW = $clog2(MAXC + 1);

   eng_state_t      st;
   logic [CW-1:0]   cnt;
   logic            cbr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ENG_IDLE;
         cnt   <= '0;
         cbr_q <= 1'b0;
      end else begin
         case (st)
            ENG_IDLE: if (go) begin
               cbr_q <= cbr;
               if (cbr) begin
                  st  <= ENG_CAS;
                  cnt <= CW'(CAS_LEAD_CYC - 1);
               end else begin
                  st  <= ENG_RAS;
                  cnt <= CW'(RAS_LOW_CYC - 1);
               end
            end
            ENG_CAS: if (cnt == '0) begin
               st  <= ENG_RAS;
               cnt <= CW'(RAS_LOW_CYC - 1);
            end else cnt <= cnt - 1'b1;
            ENG_RAS: if (cnt == '0) begin
               st  <= ENG_PRE;
               cnt <= CW'(RAS_PRE_CYC - 1);
            end else cnt <= cnt - 1'b1;
            default: if (cnt == '0) st <= ENG_IDLE;
                     else cnt <= cnt - 1'b1;
         endcase
      end
   end

   assign ras_n = (st != ENG_RAS);
   assign cas_n = !((st == ENG_CAS) || ((st == ENG_RAS) && cbr_q));
   assign busy  = (st != ENG_IDLE);
   assign done  = (st == ENG_PRE) && (cnt == '0);

   // run-length counters used only by the checks below
   logic [CW:0] low_run, hi_run;
   logic        seen_low;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_run  <= '0;
         hi_run   <= '0;
         seen_low <= 1'b0;
      end else begin
         low_run <= ras_n ? '0 : low_run + 1'b1;
         hi_run  <= (!ras_n) ? '0 : ((hi_run == '1) ? hi_run : hi_run + 1'b1);
         if (!ras_n) seen_low <= 1'b1;
      end
   end

   assert_cas_leads_ras_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ras_n) && !cas_n) |-> !$past(cas_n));
   assert_ras_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_n) |-> (low_run == (CW+1)'(RAS_LOW_CYC)));
   assert_precharge_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ras_n) && seen_low) |-> (hi_run >= (CW+1)'(RAS_PRE_CYC)));
endmodule

// File: rtl/refseq_credit.sv
module refseq_credit #(
   parameter int INTERVAL_CYC = 1560,
   parameter int PEND_MAX     = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic take,
   output logic pend_nz
);
   localparam int TW  = $clog2(INTERVAL_CYC + 1);
   localparam int PDW = $clog2(PEND_MAX + 1);

   logic [TW-1:0]  tmr;
   logic [PDW-1:0] pend;
   logic           tick;

   assign tick = en && (tmr == TW'(INTERVAL_CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tmr <= '0;
      else if (!en)    tmr <= '0;
      else if (tick)   tmr <= '0;
      else             tmr <= tmr + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= '0;
      else begin
         case ({tick, take})
            2'b10:   if (pend < PDW'(PEND_MAX)) pend <= pend + 1'b1;
            2'b01:   pend <= pend - 1'b1;
            default: pend <= pend;
         endcase
      end
   end

   assign pend_nz = (pend != '0);

   assert_pend_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pend <= PDW'(PEND_MAX));
   assert_take_has_credit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> pend_nz);
endmodule

// File: rtl/refresh_init_seq.sv
module refresh_init_seq
   import refseq_pkg::*;
#(
   parameter int PAUSE_CYC    = 20000,
   parameter int INIT_CYCLES  = 8,
   parameter int INTERVAL_CYC = 1560,
   parameter int CAS_LEAD_CYC = 1,
   parameter int RAS_LOW_CYC  = 5,
   parameter int RAS_PRE_CYC  = 4,
   parameter int PEND_MAX     = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_gnt,
   output logic ref_req,
   output logic init_done,
   output logic strobe_own,
   output logic ras_n,
   output logic lcas_n,
   output logic ucas_n,
   output logic we_n,
   output logic oe_n
);
   localparam int PW = $clog2(PAUSE_CYC + 1);
   localparam int IW = $clog2(INIT_CYCLES + 1);
   localparam int SEQ_CYC = CAS_LEAD_CYC + RAS_LOW_CYC + RAS_PRE_CYC + 1;

   generate
      if (PAUSE_CYC < 1 || INIT_CYCLES < 1 || PEND_MAX < 1)
         begin : g_bad_count $error("counts must be at least 1"); end
      if (CAS_LEAD_CYC < 1 || RAS_LOW_CYC < 1 || RAS_PRE_CYC < 1)
         begin : g_bad_strobe $error("strobe timings must be at least 1"); end
      if (INTERVAL_CYC <= SEQ_CYC)
         begin : g_bad_interval $error("interval shorter than one refresh"); end
   endgenerate

   phase_t         ph;
   logic [PW-1:0]  pause_cnt;
   logic [IW-1:0]  issued;
   logic           go, eng_ras_n, eng_cas_n, eng_busy, eng_done, pend_nz;

   assign go = !eng_busy &&
               (((ph == PH_INIT) && (issued < IW'(INIT_CYCLES))) ||
                ((ph == PH_RUN) && pend_nz && ref_gnt));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph        <= PH_PAUSE;
         pause_cnt <= '0;
         issued    <= '0;
      end else begin
         case (ph)
            PH_PAUSE: if (pause_cnt == PW'(PAUSE_CYC - 1)) ph <= PH_INIT;
                      else pause_cnt <= pause_cnt + 1'b1;
            PH_INIT: begin
               if (go) issued <= issued + 1'b1;
               if (!eng_busy && (issued == IW'(INIT_CYCLES))) ph <= PH_RUN;
            end
            default: ph <= PH_RUN;
         endcase
      end
   end

   refseq_engine #(
      .CAS_LEAD_CYC(CAS_LEAD_CYC),
      .RAS_LOW_CYC (RAS_LOW_CYC),
      .RAS_PRE_CYC (RAS_PRE_CYC)
   ) u_engine (
      .clk  (clk),
      .rst_n(rst_n),
      .go   (go),
      .cbr  (ph == PH_RUN),
      .ras_n(eng_ras_n),
      .cas_n(eng_cas_n),
      .busy (eng_busy),
      .done (eng_done)
   );

   refseq_credit #(
      .INTERVAL_CYC(INTERVAL_CYC),
      .PEND_MAX    (PEND_MAX)
   ) u_credit (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (ph == PH_RUN),
      .take   (eng_done && (ph == PH_RUN)),
      .pend_nz(pend_nz)
   );

   assign init_done  = (ph == PH_RUN);
   assign ref_req    = init_done && pend_nz;
   assign strobe_own = !init_done || eng_busy;
   assign ras_n      = eng_ras_n;
   assign lcas_n     = eng_cas_n;
   assign ucas_n     = eng_cas_n;
   assign we_n       = 1'b1;
   assign oe_n       = 1'b1;

   assert_quiet_pause_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_PAUSE) |-> (eng_ras_n && eng_cas_n));
   assert_done_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done);
   assert_init_no_cas_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!init_done && !eng_ras_n) |-> eng_cas_n);
   assert_grant_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (init_done && $fell(eng_cas_n)) |-> $past(ref_gnt));
   assert_own_in_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !eng_ras_n |-> strobe_own);
endmodule

// File: tb/refresh_init_seq_bench.sv
module refresh_init_seq_bench;
   localparam int PAUSE = 50;
   localparam int NINIT = 8;
   localparam int INTV  = 60;
   localparam int LEAD  = 2;
   localparam int LOW   = 4;
   localparam int PRE   = 3;
   localparam int PMAX  = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_gnt = 1'b0;
   logic ref_req, init_done, strobe_own, ras_n, lcas_n, ucas_n, we_n, oe_n;

   always #5 clk = ~clk;

   refresh_init_seq #(
      .PAUSE_CYC(PAUSE), .INIT_CYCLES(NINIT), .INTERVAL_CYC(INTV),
      .CAS_LEAD_CYC(LEAD), .RAS_LOW_CYC(LOW), .RAS_PRE_CYC(PRE), .PEND_MAX(PMAX)
   ) u_refresh_init_seq (
      .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
      .init_done(init_done), .strobe_own(strobe_own), .ras_n(ras_n),
      .lcas_n(lcas_n), .ucas_n(ucas_n), .we_n(we_n), .oe_n(oe_n)
   );

   int n_cmp = 0;
   int n_bad = 0;
   int t = 0;
   bit finished = 1'b0;
   bit auto_gnt = 1'b0;
   bit exp_q[$];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d (t=%0d)", req, act, exp, t);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   // monitor: classifies RAS pulses and compares against the expected queue
   bit prev_ras = 1'b1, cur_kind = 1'b0, seen = 1'b0;
   int lead = 0, low_w = 0, hi_w = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         t++;
         if (auto_gnt) ref_gnt <= ref_req;
         chk(we_n && oe_n, "R9", {we_n, oe_n}, 3);
         chk(lcas_n == ucas_n, "R4", lcas_n, ucas_n);
         if (!ras_n) begin
            chk(strobe_own, "R10", strobe_own, 1);
            if (prev_ras) begin
               cur_kind = !lcas_n;
               if (exp_q.size() == 0) chk(1'b0, "R7", cur_kind, -1);
               else begin
                  bit e;
                  e = exp_q.pop_front();
                  chk(cur_kind == e, e ? "R4" : "R2", cur_kind, e);
               end
               if (cur_kind) chk(lead == LEAD, "R4", lead, LEAD);
               if (seen) chk(hi_w >= PRE, "R6", hi_w, PRE);
               else chk(t > PAUSE, "R1", t, PAUSE);
               seen = 1'b1;
               low_w = 1;
            end else low_w++;
            chk(lcas_n == !cur_kind, cur_kind ? "R4" : "R2", lcas_n, !cur_kind);
         end else begin
            if (!prev_ras) begin
               chk(low_w == LOW, "R5", low_w, LOW);
               chk(lcas_n, "R4", lcas_n, 1);
               hi_w = 1;
            end else hi_w++;
            lead = lcas_n ? 0 : lead + 1;
         end
         prev_ras = ras_n;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      chk(1'b0, "watchdog", t, 0);
      finish_run();
   end

   initial begin
      int t_done, t_prev, w;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(ras_n && lcas_n && ucas_n, "R11", {ras_n, lcas_n, ucas_n}, 7);
      chk(!init_done && !ref_req, "R11", {init_done, ref_req}, 0);
      chk(strobe_own, "R10", strobe_own, 1);
      for (int i = 0; i < NINIT; i++) exp_q.push_back(1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(strobe_own && !init_done, "R10", strobe_own, 1);
      w = 0;
      while (!init_done && w < 2000) begin @(negedge clk); w++; end
      chk(init_done, "R2", init_done, 1);
      chk(exp_q.size() == 0, "R2", exp_q.size(), 0);
      t_done = t;
      @(negedge clk);
      chk(!strobe_own && !ref_req, "R10", {strobe_own, ref_req}, 0);

      // regular refreshes with prompt grant
      auto_gnt = 1'b1;
      t_prev = t_done;
      for (int k = 0; k < 3; k++) begin
         w = 0;
         while (ref_req && w < 3 * INTV) begin @(negedge clk); w++; end
         while (!ref_req && w < 3 * INTV) begin @(negedge clk); w++; end
         exp_q.push_back(1'b1);
         if (k == 0) chk((t - t_done >= INTV - 2) && (t - t_done <= INTV + 2), "R3", t - t_done, INTV);
         else chk(t - t_prev == INTV, "R3", t - t_prev, INTV);
         t_prev = t;
      end
      w = 0;
      while (ref_req && w < 100) begin @(negedge clk); w++; end
      repeat (LEAD + LOW + PRE + 4) @(negedge clk);
      auto_gnt = 1'b0;
      ref_gnt = 1'b0;
      chk(exp_q.size() == 0, "R7", exp_q.size(), 0);

      // withheld grant: credits saturate, then drain back to back
      w = 0;
      while (!ref_req && w < 2 * INTV) begin @(negedge clk); w++; end
      repeat (5 * INTV + 5) @(negedge clk);
      chk(ref_req && !strobe_own, "R7", {ref_req, strobe_own}, 2);
      for (int i = 0; i < PMAX; i++) exp_q.push_back(1'b1);
      ref_gnt = 1'b1;
      t_prev = t;
      w = 0;
      while (ref_req && w < 100) begin @(negedge clk); w++; end
      ref_gnt = 1'b0;
      chk(!ref_req, "R8", ref_req, 0);
      chk(t - t_prev <= PMAX * (LEAD + LOW + PRE + 1) + 3, "R8", t - t_prev,
          PMAX * (LEAD + LOW + PRE + 1) + 3);
      repeat (10) @(negedge clk);
      chk(exp_q.size() == 0, "R8", exp_q.size(), 0);
      chk(!strobe_own && ras_n, "R10", strobe_own, 0);
      chk(init_done, "R2", init_done, 1);
      finish_run();
   end
endmodule